// File: doc/BRIEF.md
# Masked Vector-Immediate Integer ALU

This block executes one vector-immediate integer operation on every element of a register group in a single step. It receives a packed source vector, the previous destination vector, a per-element mask and the instruction's operands: a 6-bit operation code, a 5-bit immediate and an element-width selector. It produces the new destination vector. Each active element gets the computed value. Each inactive element keeps its previous content.

The datapath is combinational, and its result is captured in an output register when `start` is high. The operations are wrapping add, reverse subtract, the three bitwise logic operations, unsigned and signed saturating add, logical left and right shifts, arithmetic right shift, and the two rounding scaling shifts. A sticky flag records that some active element was clamped by a saturating add. The flag stays set until reset. A one-cycle valid pulse marks each finished operation, which tells the surrounding pipeline that the vector start index may return to zero.

Top module: `vimm_alu`

## Requirements
- R1: Operation codes are: add 6'b000000, reverse subtract 6'b000011, AND 6'b001001, OR 6'b001010, XOR 6'b001011, unsigned saturating add 6'b100000, signed saturating add 6'b100001, shift left 6'b100101, logical right shift 6'b101000, arithmetic right shift 6'b101001, rounding logical shift 6'b101010, rounding arithmetic shift 6'b101011. Add returns element plus the sign-extended immediate, modulo 2^SEW.
- R2: Reverse subtract returns the sign-extended immediate minus the element, modulo 2^SEW.
- R3: AND, OR and XOR combine the element with the sign-extended immediate bit by bit.
- R4: Unsigned saturating add clamps to 2^SEW-1 when the unsigned sum exceeds that value. Otherwise it returns the sum.
- R5: Signed saturating add clamps to the most positive or most negative SEW-bit value when the signed sum falls out of range.
- R6: Every shift uses the zero-extended immediate, cut to its low log2(SEW) bits, as the shift amount. Left and logical right shifts fill with zeros.
- R7: Arithmetic right shift fills the vacated bits with copies of the element's sign bit.
- R8: The rounding shifts add an increment to the shifted value. The increment is chosen by `rndMode`: 0 adds the last bit shifted out. 1 adds that bit only when a lower shifted-out bit is set or the result's LSB is odd. 2 adds nothing. 3 adds one when the result's LSB is 0 and any shifted-out bit is set. A shift amount of 0 adds nothing.
- R9: Element i is controlled by `maskVec[i]`. When `maskEn` is 1 and that bit is 0, the element keeps its `oldDst` value. When `maskEn` is 0, all elements are active.
- R10: `satFlag` goes high after any operation in which an active element of a saturating add is clamped. Clamping in inactive elements does not set it. The flag stays high until reset.
- R11: An operation code outside the R1 list leaves every element equal to `oldDst` and never sets `satFlag`.
- R12: `dstVec` and a one-cycle `resValid` pulse appear on the clock edge that samples `start` high. `dstVec` holds its value while `start` is low. Reset clears `dstVec`, `resValid` and `satFlag`.
- R13: `sewSel` selects the element width: 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. Element i occupies bits i*SEW upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Execute the operation presented this cycle |
| sewSel | input | 2 | Element width selector |
| opCode | input | 6 | Operation code |
| imm5 | input | 5 | Immediate operand |
| maskEn | input | 1 | Enable per-element masking |
| rndMode | input | 2 | Rounding mode for scaling shifts |
| srcVec | input | VLEN | Source element vector |
| oldDst | input | VLEN | Previous destination vector |
| maskVec | input | VLEN/8 | Per-element mask bits |
| dstVec | output | VLEN | New destination vector (registered) |
| resValid | output | 1 | One-cycle completion pulse |
| satFlag | output | 1 | Sticky saturation flag |

## Verification
A wrong decode or a wrong immediate extension shows up as a corrupted `dstVec` element in the first cycle after `start`. The mismatch appears only at the element widths where the sign or the shift-amount truncation matters, so each operation runs at several widths. A faulty mask path shows as an inactive lane that differs from `oldDst`, or as an active lane that kept its old value, in the same cycle. A bad sticky or clamp path shows through `satFlag`: it either rises on an operation that must not set it, or it drops on a later operation.

// File: rtl/vimm_pkg.sv
package vimm_pkg;
  localparam logic [5:0] OP_ADD  = 6'b000000;
  localparam logic [5:0] OP_RSUB = 6'b000011;
  localparam logic [5:0] OP_AND  = 6'b001001;
  localparam logic [5:0] OP_OR   = 6'b001010;
  localparam logic [5:0] OP_XOR  = 6'b001011;
  localparam logic [5:0] OP_SATU = 6'b100000;
  localparam logic [5:0] OP_SATS = 6'b100001;
  localparam logic [5:0] OP_SLL  = 6'b100101;
  localparam logic [5:0] OP_SRL  = 6'b101000;
  localparam logic [5:0] OP_SRA  = 6'b101001;
  localparam logic [5:0] OP_SSRL = 6'b101010;
  localparam logic [5:0] OP_SSRA = 6'b101011;

  typedef enum logic [1:0] {
    RND_NEAR_UP = 2'd0,
    RND_NEAR_EVEN = 2'd1,
    RND_DOWN = 2'd2,
    RND_ODD = 2'd3
  } rnd_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic known;
    logic opAdd;
    logic opRsub;
    logic opAnd;
    logic opOr;
    logic opXor;
    logic opSatU;
    logic opSatS;
    logic opSll;
    logic opSrl;
    logic opSra;
    logic opRound;
  } ctrl_t;
endpackage

// File: rtl/vimm_elem.sv
module vimm_elem
  import vimm_pkg::*;
#(
  parameter int W = 8
) (
  input  ctrl_t        ctl,
  input  logic [4:0]   imm5,
  input  logic [1:0]   rndMode,
  input  logic [W-1:0] src,
  output logic [W-1:0] res,
  output logic         sat
);
  localparam int SHW = $clog2(W);

  logic [W-1:0]   immS;
  logic [5:0]     imm6;
  logic [SHW-1:0] shamt;
  logic [W:0]     sumU;
  logic [W:0]     sumS;
  logic           ovfU;
  logic           ovfS;
  logic [2*W-1:0] sraWide;
  logic [2*W-1:0] sraShift;
  logic [W-1:0]   srlRes;
  logic [W-1:0]   sraRes;
  logic [W-1:0]   unitAt;
  logic [W-1:0]   halfBit;
  logic [W-1:0]   lowMask;
  logic           roundBit;
  logic           belowAny;
  logic           lowAny;
  logic           lsbOut;
  logic           incr;

  assign immS = {{(W-5){imm5[4]}}, imm5};
  assign imm6 = {1'b0, imm5};
  assign shamt = imm6[SHW-1:0];

  assign sumU = {1'b0, src} + {1'b0, immS};
  assign sumS = {src[W-1], src} + {immS[W-1], immS};
  assign ovfU = sumU[W];
  assign ovfS = sumS[W] ^ sumS[W-1];

  assign sraWide  = {{W{src[W-1]}}, src};
  assign sraShift = sraWide >> shamt;
  assign sraRes   = sraShift[W-1:0];
  assign srlRes   = src >> shamt;

  // Rounding terms built from the bits that the shift discards.
  assign unitAt   = {{(W-1){1'b0}}, 1'b1} << shamt;
  assign halfBit  = unitAt >> 1;
  assign lowMask  = unitAt - 1'b1;
  assign roundBit = |(src & halfBit);
  assign belowAny = |(src & (halfBit - 1'b1)) & (halfBit != '0);
  assign lowAny   = |(src & lowMask);
  assign lsbOut   = |(src & unitAt);

  always_comb begin
    unique case (rnd_t'(rndMode))
      RND_NEAR_UP:   incr = roundBit;
      RND_NEAR_EVEN: incr = roundBit & (belowAny | lsbOut);
      RND_DOWN:      incr = 1'b0;
      RND_ODD:       incr = ~lsbOut & lowAny;
      default:       incr = 1'b0;
    endcase
  end

  always_comb begin
    res = '0;
    sat = 1'b0;
    if (ctl.opAdd)  res = src + immS;
    if (ctl.opRsub) res = immS - src;
    if (ctl.opAnd)  res = src & immS;
    if (ctl.opOr)   res = src | immS;
    if (ctl.opXor)  res = src ^ immS;
    if (ctl.opSatU) begin
      res = ovfU ? '1 : sumU[W-1:0];
      sat = ovfU;
    end
    if (ctl.opSatS) begin
      sat = ovfS;
      if (ovfS) res = sumS[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
      else res = sumS[W-1:0];
    end
    if (ctl.opSll) res = src << shamt;
    if (ctl.opSrl) res = srlRes + (ctl.opRound ? {{(W-1){1'b0}}, incr} : '0);
    if (ctl.opSra) res = sraRes + (ctl.opRound ? {{(W-1){1'b0}}, incr} : '0);
  end
endmodule

// File: rtl/vimm_ctrl.sv
module vimm_ctrl
  import vimm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [5:0] opCode,
  input  logic       satAny,
  output ctrl_t      ctl,
  output logic       resValid,
  output logic       satFlag
);
  always_comb begin
    ctl = '0;
    unique case (opCode)
      OP_ADD:  ctl.opAdd  = 1'b1;
      OP_RSUB: ctl.opRsub = 1'b1;
      OP_AND:  ctl.opAnd  = 1'b1;
      OP_OR:   ctl.opOr   = 1'b1;
      OP_XOR:  ctl.opXor  = 1'b1;
      OP_SATU: ctl.opSatU = 1'b1;
      OP_SATS: ctl.opSatS = 1'b1;
      OP_SLL:  ctl.opSll  = 1'b1;
      OP_SRL:  ctl.opSrl  = 1'b1;
      OP_SRA:  ctl.opSra  = 1'b1;
      OP_SSRL: begin ctl.opSrl = 1'b1; ctl.opRound = 1'b1; end
      OP_SSRA: begin ctl.opSra = 1'b1; ctl.opRound = 1'b1; end
      default: ctl = '0;
    endcase
    ctl.known = ctl.opAdd | ctl.opRsub | ctl.opAnd | ctl.opOr | ctl.opXor |
                ctl.opSatU | ctl.opSatS | ctl.opSll | ctl.opSrl | ctl.opSra;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      satFlag  <= 1'b0;
    end else begin
      resValid <= start;
      if (start && satAny) satFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/vimm_datapath.sv
module vimm_datapath
  import vimm_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  ctrl_t             ctl,
  input  logic [1:0]        sewSel,
  input  logic [4:0]        imm5,
  input  logic              maskEn,
  input  logic [1:0]        rndMode,
  input  logic [VLEN-1:0]   srcVec,
  input  logic [VLEN-1:0]   oldDst,
  input  logic [VLEN/8-1:0] maskVec,
  output logic              satAny,
  output logic [VLEN-1:0]   dstVec
);
  localparam int NW = 4;

  logic [VLEN-1:0] resW [NW];
  logic [NW-1:0]   satW;
  logic [VLEN-1:0] nextDst;

  for (genvar g = 0; g < NW; g++) begin : g_sew
    localparam int W = 8 << g;
    localparam int N = VLEN / W;
    logic [N-1:0] satE;
    for (genvar e = 0; e < N; e++) begin : g_el
      logic [W-1:0] r;
      logic         s;
      logic         act;
      vimm_elem #(.W(W)) u_elem (
        .ctl(ctl), .imm5(imm5), .rndMode(rndMode),
        .src(srcVec[e*W +: W]), .res(r), .sat(s)
      );
      assign act = ctl.known & (~maskEn | maskVec[e]);
      assign resW[g][e*W +: W] = act ? r : oldDst[e*W +: W];
      assign satE[e] = act & s;
    end
    assign satW[g] = |satE;
  end

  assign nextDst = resW[sewSel];
  assign satAny  = satW[sewSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dstVec <= '0;
    else if (start) dstVec <= nextDst;
  end
endmodule

// File: rtl/vimm_alu.sv
module vimm_alu
  import vimm_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        sewSel,
  input  logic [5:0]        opCode,
  input  logic [4:0]        imm5,
  input  logic              maskEn,
  input  logic [1:0]        rndMode,
  input  logic [VLEN-1:0]   srcVec,
  input  logic [VLEN-1:0]   oldDst,
  input  logic [VLEN/8-1:0] maskVec,
  output logic [VLEN-1:0]   dstVec,
  output logic              resValid,
  output logic              satFlag
);
  ctrl_t ctl;
  logic  satAny;

  vimm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .satAny(satAny),
    .ctl(ctl), .resValid(resValid), .satFlag(satFlag)
  );

  vimm_datapath #(.VLEN(VLEN)) u_dp (
    .clk(clk), .rstN(rstN), .start(start), .ctl(ctl), .sewSel(sewSel),
    .imm5(imm5), .maskEn(maskEn), .rndMode(rndMode), .srcVec(srcVec),
    .oldDst(oldDst), .maskVec(maskVec), .satAny(satAny), .dstVec(dstVec)
  );
endmodule

// File: rtl/vimm_alu_chk.sv
module vimm_alu_chk #(
  parameter int VLEN = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [5:0]        opCode,
  input logic              maskEn,
  input logic [VLEN-1:0]   oldDst,
  input logic [VLEN/8-1:0] maskVec,
  input logic [VLEN-1:0]   dstVec,
  input logic              resValid,
  input logic              satFlag
);
  logic isKnown;
  logic isSatOp;
  assign isSatOp = (opCode == 6'b100000) || (opCode == 6'b100001);
  assign isKnown = isSatOp || (opCode == 6'b000000) || (opCode == 6'b000011) ||
                   (opCode == 6'b001001) || (opCode == 6'b001010) ||
                   (opCode == 6'b001011) || (opCode == 6'b100101) ||
                   (opCode[5:2] == 4'b1010);

  assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    start |=> resValid);
  assert_valid_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !resValid);
  assert_dst_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> $stable(dstVec));
  assert_sat_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    satFlag |=> satFlag);
  assert_sat_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    start && !(isSatOp && isKnown) && !satFlag |=> !satFlag);
  assert_unknown_keeps_R11: assert property (@(posedge clk) disable iff (!rstN)
    start && !isKnown |=> dstVec == $past(oldDst));
  assert_all_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    start && maskEn && (maskVec == '0) |=> dstVec == $past(oldDst));
endmodule

bind vimm_alu vimm_alu_chk #(.VLEN(VLEN)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .maskEn(maskEn),
  .oldDst(oldDst), .maskVec(maskVec), .dstVec(dstVec), .resValid(resValid),
  .satFlag(satFlag)
);

// File: tb/vimm_alu_tb.sv
`timescale 1ns/1ps
module vimm_alu_tb;
  localparam int VLEN = 128;
  localparam int NM = VLEN / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] sewSel = '0;
  logic [5:0] opCode = '0;
  logic [4:0] imm5 = '0;
  logic maskEn = 1'b0;
  logic [1:0] rndMode = '0;
  logic [VLEN-1:0] srcVec = '0;
  logic [VLEN-1:0] oldDst = '0;
  logic [NM-1:0] maskVec = '0;
  logic [VLEN-1:0] dstVec;
  logic resValid;
  logic satFlag;

  int checks = 0;
  int errors = 0;
  logic expSat = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  vimm_alu #(.VLEN(VLEN)) u_dut (.*);

  task automatic chk(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [64:0] sext(input logic [63:0] v, input int w);
    logic [64:0] e = {1'b0, v};
    if (v[w-1]) e = e | ~((65'd1 << w) - 65'd1);
    return e;
  endfunction

  function automatic logic [63:0] refElem(input int w, input logic [5:0] op,
      input logic [4:0] im, input logic [1:0] rm, input logic [63:0] s, output logic sat);
    logic [63:0] msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    logic [63:0] immS = {{59{im[4]}}, im} & msk;
    int d = int'(im) & (w - 1);
    logic [64:0] t, ea, eb, maxv, minv;
    logic [63:0] r = '0;
    logic rb, below, lsb, anyl, inc;
    sat = 1'b0;
    ea = sext(s, w);
    eb = sext(immS, w);
    maxv = (65'd1 << (w - 1)) - 65'd1;
    minv = ~maxv;
    rb = (d > 0) ? s[d-1] : 1'b0;
    below = (d > 1) ? ((s & ((64'd1 << (d - 1)) - 64'd1)) != 0) : 1'b0;
    lsb = s[d];
    anyl = (d > 0) ? ((s & ((64'd1 << d) - 64'd1)) != 0) : 1'b0;
    case (rm)
      2'd0: inc = rb;
      2'd1: inc = rb & (below | lsb);
      2'd2: inc = 1'b0;
      default: inc = ~lsb & anyl;
    endcase
    case (op)
      6'b000000: r = s + immS;
      6'b000011: r = immS - s;
      6'b001001: r = s & immS;
      6'b001010: r = s | immS;
      6'b001011: r = s ^ immS;
      6'b100000: begin
        t = {1'b0, s} + {1'b0, immS};
        if ((t >> w) != 0) begin r = msk; sat = 1'b1; end
        else r = t[63:0];
      end
      6'b100001: begin
        t = ea + eb;
        if ($signed(t) > $signed(maxv)) begin r = maxv[63:0]; sat = 1'b1; end
        else if ($signed(t) < $signed(minv)) begin r = minv[63:0]; sat = 1'b1; end
        else r = t[63:0];
      end
      6'b100101: r = s << d;
      6'b101000: r = s >> d;
      6'b101001: begin t = 65'($signed(ea) >>> d); r = t[63:0]; end
      6'b101010: r = (s >> d) + {63'd0, inc};
      6'b101011: begin t = 65'($signed(ea) >>> d); r = t[63:0] + {63'd0, inc}; end
      default: r = s;
    endcase
    return r & msk;
  endfunction

  function automatic logic knownOp(input logic [5:0] op);
    return op inside {6'b000000, 6'b000011, 6'b001001, 6'b001010, 6'b001011, 6'b100000,
                      6'b100001, 6'b100101, 6'b101000, 6'b101001, 6'b101010, 6'b101011};
  endfunction

  task automatic runCase(input string req, input logic [1:0] sw, input logic [5:0] op,
      input logic [4:0] im, input logic me, input logic [NM-1:0] mv, input logic [1:0] rm,
      input logic [VLEN-1:0] s, input logic [VLEN-1:0] o);
    int w = 8 << sw;
    logic [VLEN-1:0] exp = '0;
    logic [VLEN-1:0] m = (w == 64) ? {VLEN{1'b1}} >> (VLEN - 64) : ((VLEN'(1) << w) - 1'b1);
    logic [VLEN-1:0] held;
    for (int i = 0; i < VLEN / w; i++) begin
      logic [63:0] se = 64'((s >> (i * w)) & m);
      logic es;
      logic [63:0] re = refElem(w, op, im, rm, se, es);
      if (knownOp(op) && (!me || mv[i])) begin
        exp |= VLEN'(re) << (i * w);
        expSat |= es;
      end else begin
        exp |= ((o >> (i * w)) & m) << (i * w);
      end
    end
    @(negedge clk);
    sewSel = sw; opCode = op; imm5 = im; maskEn = me; maskVec = mv; rndMode = rm;
    srcVec = s; oldDst = o; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " result"}, dstVec, exp);
    chk("R12 valid pulse", VLEN'(resValid), VLEN'(1));
    chk({req, " R10 sat flag"}, VLEN'(satFlag), VLEN'(expSat));
    held = dstVec;
    srcVec = ~s; oldDst = ~o;
    @(negedge clk);
    chk("R12 valid low", VLEN'(resValid), VLEN'(0));
    chk("R12 dst hold", dstVec, held);
  endtask

  function automatic logic [VLEN-1:0] pat(input int k);
    logic [VLEN-1:0] v = '0;
    for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = 32'h9E3779B9 * (k * 7 + i + 1);
    return v;
  endfunction

  task automatic testReset();
    chk("R12 reset dst", dstVec, '0);
    chk("R12 reset valid", VLEN'(resValid), '0);
    chk("R12 reset sat", VLEN'(satFlag), '0);
  endtask

  task automatic testArith();
    for (int sw = 0; sw < 4; sw++) begin
      runCase("R1 R13 add", 2'(sw), 6'b000000, 5'h13, 1'b0, '0, 2'd0, pat(sw), pat(9));
      runCase("R2 rsub", 2'(sw), 6'b000011, 5'h05, 1'b0, '0, 2'd0, pat(sw + 4), pat(9));
    end
  endtask

  task automatic testLogic();
    runCase("R3 and", 2'd1, 6'b001001, 5'h1A, 1'b0, '0, 2'd0, pat(1), pat(2));
    runCase("R3 or", 2'd3, 6'b001010, 5'h0C, 1'b0, '0, 2'd0, pat(3), pat(2));
    runCase("R3 xor", 2'd0, 6'b001011, 5'h11, 1'b0, '0, 2'd0, pat(5), pat(2));
  endtask

  task automatic testMask();
    runCase("R9 masked add", 2'd0, 6'b000000, 5'h01, 1'b1, 16'hA5C3, 2'd0, pat(6), pat(7));
    runCase("R9 masked sll", 2'd2, 6'b100101, 5'h03, 1'b1, 16'h0005, 2'd0, pat(8), pat(7));
    // R10: clamping only in an inactive element must leave the flag low.
    runCase("R10 inactive sat", 2'd0, 6'b100000, 5'h1F, 1'b1, 16'h0000, 2'd0, {VLEN{1'b1}}, pat(4));
  endtask

  task automatic testUnknown();
    runCase("R11 unknown op", 2'd0, 6'b000001, 5'h1F, 1'b0, '0, 2'd0, {VLEN{1'b1}}, pat(3));
    runCase("R11 unknown op2", 2'd3, 6'b111111, 5'h0F, 1'b0, '0, 2'd0, pat(1), pat(5));
  endtask

  task automatic testSat();
    runCase("R4 satu no clamp", 2'd1, 6'b100000, 5'h01, 1'b0, '0, 2'd0, {VLEN/16{16'h1234}}, pat(1));
    chk("R10 still low", VLEN'(satFlag), '0);
    runCase("R4 satu clamp", 2'd0, 6'b100000, 5'h02, 1'b0, '0, 2'd0, {VLEN/8{8'hFE}}, pat(1));
    runCase("R5 sats pos", 2'd2, 6'b100001, 5'h0F, 1'b0, '0, 2'd0, {VLEN/32{32'h7FFFFFF8}}, pat(1));
    runCase("R5 sats neg", 2'd3, 6'b100001, 5'h10, 1'b0, '0, 2'd0, {VLEN/64{64'h8000000000000005}}, pat(1));
    runCase("R5 sats mix", 2'd0, 6'b100001, 5'h1C, 1'b0, '0, 2'd0, pat(11), pat(1));
    runCase("R10 sticky", 2'd0, 6'b000000, 5'h00, 1'b0, '0, 2'd0, pat(2), pat(1));
  endtask

  task automatic testShift();
    for (int sw = 0; sw < 4; sw++) begin
      runCase("R6 sll", 2'(sw), 6'b100101, 5'h1F, 1'b0, '0, 2'd0, pat(sw), pat(1));
      runCase("R6 srl", 2'(sw), 6'b101000, 5'h0B, 1'b0, '0, 2'd0, pat(sw + 2), pat(1));
      runCase("R7 sra", 2'(sw), 6'b101001, 5'h1D, 1'b0, '0, 2'd0, pat(sw + 3), pat(1));
    end
  endtask

  task automatic testRound();
    for (int rm = 0; rm < 4; rm++) begin
      runCase("R8 ssrl", 2'd0, 6'b101010, 5'h02, 1'b0, '0, 2'(rm), 128'h0F0E0D0C0B0A09080706050403020100, pat(1));
      runCase("R8 ssra", 2'd1, 6'b101011, 5'h03, 1'b0, '0, 2'(rm), pat(rm + 12), pat(1));
      runCase("R8 ssrl zero shift", 2'd2, 6'b101010, 5'h00, 1'b0, '0, 2'(rm), pat(rm), pat(1));
      runCase("R8 ssra wide", 2'd3, 6'b101011, 5'h11, 1'b0, '0, 2'(rm), pat(rm + 20), pat(1));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testArith();
    testLogic();
    testMask();
    testUnknown();
    testShift();
    testRound();
    testSat();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule